// File: doc/BRIEF.md
# Tree-Search Soft Decoder for Space-Coded 4-PAM

This block takes three quantised soft samples per clock, one from each line of a three-line bus, and recovers the 5-bit data word that a space-coded 4-PAM transmitter put on the bus. The transmitter splits the four amplitude levels into two subsets, each with twice the spacing of the full alphabet. The subset choice is coded across the lines by a two-state code, and that trellis is forced back to state zero at the third line. Only four paths through the three lines are therefore possible.

The decoder does not run a sequential add-compare-select unit with survivor memory. It treats the four paths as leaves of a tree and searches all of them at once. For every line it computes the distance from the sample to the nearest point of each subset, so the two parallel branches per state pair are merged. It adds three such distances per leaf and compares all six leaf pairs. A 12-input decoder then turns the six pairwise results and the six per-line threshold results into the data word. Sample width and level spacing are parameters. The pipeline has three register stages, and a valid flag travels with the data.

Top module: `tsd_top`

## Requirements
- R1: Line k's sample is the two's-complement field `in_samples[k*SW +: SW]`, with nominal levels -3S, -S, +S, +3S (S = `LEVEL_STEP`). Subset A is {-3S, +S} and subset B is {-S, +3S}; a within-subset bit of 1 selects the upper point. In the data word, bit 0 is line 0's within-subset bit, bit 1 is path bit p0, bit 2 is line 1's within-subset bit, bit 3 is path bit p1 and bit 4 is line 2's within-subset bit. Line 0 uses subset p0, line 1 uses subset p0 xor p1 and line 2 uses subset p1 (0 = A, 1 = B).
- R2: For noise-free samples produced by the R1 mapping, all 32 data words are recovered exactly.
- R3: A sample set presented with `in_valid` high before rising edge n appears on `out_data` with `out_valid` high after rising edge n+2, a fixed three-edge latency. `out_valid` is `in_valid` delayed by the same three edges.
- R4: While `out_valid` is low, `out_data` keeps the last decoded word.
- R5: On each line and for each subset, the within-subset bit picks the nearer of the two points. A sample exactly at the midpoint picks the upper point.
- R6: The decoded path is the leaf whose summed per-line distance |x - point| to the nearer subset point is smallest. Exactly one leaf wins on every cycle.
- R7: When leaves tie on path metric, the lowest leaf index wins, where leaf index = 2*p0 + p1.
- R8: While `rst_n` is low, from the first rising edge on, `out_valid` and `out_data` are zero.
- R9: Full-scale samples, the most negative and the most positive codes, are decoded by the R6 rule with no wrap-around in any metric.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks the sample set as valid |
| in_samples | input | 3*SW | Signed soft samples; line k sits in bits [k*SW +: SW] |
| out_valid | output | 1 | Marks `out_data` as a newly decoded word |
| out_data | output | 5 | Decoded data word (bit order as in R1) |

## Verification
The first pattern drives all 32 words noise-free through the R1 mapping. This shows whether leaf metrics, the leaf numbering and the 12-to-5 bit order agree with the encoder. Noisy versions of random words and fully random sample sets then test the minimum choice against a reference that measures distances directly. The zero sample and midpoint samples make every leaf tie, or put a sample exactly on a subset threshold, which isolates the R5 and R7 tie rules. Rail codes on every line check R9. Gaps in `in_valid` separate the latency and hold behaviour from the decoding itself.

// File: rtl/tsd_pkg.sv
// Package: shared constants and helpers for the tree-search decoder.
// Assumes exactly three bus lines and a trellis forced to zero at line 2.
package tsd_pkg;
    localparam int NUM_LINES  = 3;
    localparam int NUM_LEAVES = 4;
    localparam int NUM_PAIRS  = NUM_LEAVES * (NUM_LEAVES - 1) / 2;
    localparam int DATA_BITS  = 5;

    // Flat index of the comparator for leaf pair (i, j), i < j
    function automatic int pair_idx(input int i, input int j);
        return i * (2 * NUM_LEAVES - i - 1) / 2 + (j - i - 1);
    endfunction

    // Subset used by a line on a given leaf (leaf = 2*p0 + p1)
    function automatic int leaf_subset(input int leaf, input int line);
        int p0;
        int p1;
        p0 = leaf / 2;
        p1 = leaf % 2;
        if (line == 0) return p0;
        if (line == 1) return p0 ^ p1;
        return p1;
    endfunction
endpackage

// File: rtl/tsd_branch_unit.sv
// Branch unit: merged branch metrics for one line.
// For each subset it gives the distance |x - p| to the nearer point and
// a threshold flag that tells which point that is (1 = upper; a tie at
// the midpoint counts as upper). Assumes 3*STEP < 2**(SW-1), so that the
// points lie inside the sample range and MW bits hold any distance.
module tsd_branch_unit #(
    parameter int SW   = 4,
    parameter int STEP = 2,
    parameter int MW   = SW + 1
) (
    input  logic signed [SW-1:0] x,
    output logic        [MW-1:0] bm_a,
    output logic        [MW-1:0] bm_b,
    output logic                 up_a,
    output logic                 up_b
);
    localparam int EW = SW + 3;
    localparam logic signed [EW-1:0] P_M3 = EW'(-3 * STEP);
    localparam logic signed [EW-1:0] P_M1 = EW'(-STEP);
    localparam logic signed [EW-1:0] P_P1 = EW'(STEP);
    localparam logic signed [EW-1:0] P_P3 = EW'(3 * STEP);

    logic signed [EW-1:0] xe;
    logic signed [EW-1:0] diff_a;
    logic signed [EW-1:0] diff_b;
    logic signed [EW-1:0] mag_a;
    logic signed [EW-1:0] mag_b;

    // Sign-extend the sample and apply the two thresholds
    always_comb begin
        xe   = {{3{x[SW-1]}}, x};
        up_a = (xe >= P_M1);
        up_b = (xe >= P_P1);
    end

    // Distance to the nearer point of each subset, without squaring
    always_comb begin
        diff_a = up_a ? (xe - P_P1) : (xe - P_M3);
        diff_b = up_b ? (xe - P_P3) : (xe - P_M1);
        mag_a  = diff_a[EW-1] ? -diff_a : diff_a;
        mag_b  = diff_b[EW-1] ? -diff_b : diff_b;
        bm_a   = mag_a[MW-1:0];
        bm_b   = mag_b[MW-1:0];
    end
endmodule

// File: rtl/tsd_leaf_min.sv
// Leaf minimum finder: flash comparison of every pair of leaf metrics.
// The output bit for pair (i, j), i < j, is 1 when metric i <= metric j,
// so a tie favours the lower index. Pure combinational logic.
module tsd_leaf_min
    import tsd_pkg::*;
#(
    parameter int PW = 7
) (
    input  logic [NUM_LEAVES-1:0][PW-1:0] pm,
    output logic [NUM_PAIRS-1:0]          pair_le
);
    // One comparator per leaf pair
    for (genvar i = 0; i < NUM_LEAVES; i++) begin : g_row
        for (genvar j = i + 1; j < NUM_LEAVES; j++) begin : g_col
            localparam int K = pair_idx(i, j);
            assign pair_le[K] = (pm[i] <= pm[j]);
        end
    end
endmodule

// File: rtl/tsd_bit_decoder.sv
// Output decoder: maps the six pairwise results and the six threshold
// flags (12 signals) onto the 5-bit data word. The winning leaf gives the
// path bits; the threshold flag of the subset on that path gives each
// within-subset bit. Assumes the threshold flag layout {up_b, up_a} per line.
module tsd_bit_decoder
    import tsd_pkg::*;
(
    input  logic [NUM_PAIRS-1:0]   pair_le,
    input  logic [2*NUM_LINES-1:0] thr,
    output logic [NUM_LEAVES-1:0]  win,
    output logic [DATA_BITS-1:0]   data
);
    // A leaf wins when it beats every higher leaf and ties no lower leaf
    for (genvar l = 0; l < NUM_LEAVES; l++) begin : g_win
        logic [NUM_LEAVES-1:0] beats;
        for (genvar j = 0; j < NUM_LEAVES; j++) begin : g_vs
            if (j > l) begin : g_hi
                assign beats[j] = pair_le[pair_idx(l, j)];
            end else if (j < l) begin : g_lo
                assign beats[j] = ~pair_le[pair_idx(j, l)];
            end else begin : g_self
                assign beats[j] = 1'b1;
            end
        end
        assign win[l] = &beats;
    end

    logic p0;
    logic p1;
    logic s_mid;

    // Path bits from the winner, then select the within-subset bits
    always_comb begin
        p0      = win[2] | win[3];
        p1      = win[1] | win[3];
        s_mid   = p0 ^ p1;
        data[0] = p0    ? thr[1] : thr[0];
        data[1] = p0;
        data[2] = s_mid ? thr[3] : thr[2];
        data[3] = p1;
        data[4] = p1    ? thr[5] : thr[4];
    end
endmodule

// File: rtl/tsd_top.sv
// Tree-search soft decoder for three-line space-coded 4-PAM.
// Stage 1 registers the samples. Stage 2 registers the four leaf metrics
// and the six threshold flags. Stage 3 registers the decoded word.
// Assumes deskewed, sampled lines and 3*LEVEL_STEP < 2**(SW-1).
module tsd_top
    import tsd_pkg::*;
#(
    parameter int SW         = 4,
    parameter int LEVEL_STEP = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [NUM_LINES*SW-1:0]  in_samples,
    output logic                     out_valid,
    output logic [DATA_BITS-1:0]     out_data
);
    localparam int MW = SW + 1;
    localparam int PW = MW + 2;

    logic [NUM_LINES*SW-1:0]          s1_samples;
    logic                             s1_valid;
    logic [NUM_LINES-1:0][MW-1:0]     bm_a;
    logic [NUM_LINES-1:0][MW-1:0]     bm_b;
    logic [2*NUM_LINES-1:0]           thr;
    logic [NUM_LEAVES-1:0][PW-1:0]    pm;
    logic [NUM_LEAVES-1:0][PW-1:0]    s2_pm;
    logic [2*NUM_LINES-1:0]           s2_thr;
    logic                             s2_valid;
    logic [NUM_PAIRS-1:0]             pair_le;
    logic [NUM_LEAVES-1:0]            win;
    logic [DATA_BITS-1:0]             dec_data;

    // Stage 1: capture the raw samples and their valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_samples <= '0;
            s1_valid   <= 1'b0;
        end else begin
            s1_samples <= in_samples;
            s1_valid   <= in_valid;
        end
    end

    // One branch unit per line
    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        tsd_branch_unit #(
            .SW   (SW),
            .STEP (LEVEL_STEP),
            .MW   (MW)
        ) i_branch (
            .x    (s1_samples[k*SW +: SW]),
            .bm_a (bm_a[k]),
            .bm_b (bm_b[k]),
            .up_a (thr[2*k]),
            .up_b (thr[2*k+1])
        );
    end

    // Leaf metrics: sum the merged branch metric of each line's subset
    for (genvar l = 0; l < NUM_LEAVES; l++) begin : g_leaf
        localparam int SUB0 = leaf_subset(l, 0);
        localparam int SUB1 = leaf_subset(l, 1);
        localparam int SUB2 = leaf_subset(l, 2);
        logic [MW-1:0] b0;
        logic [MW-1:0] b1;
        logic [MW-1:0] b2;
        assign b0    = (SUB0 != 0) ? bm_b[0] : bm_a[0];
        assign b1    = (SUB1 != 0) ? bm_b[1] : bm_a[1];
        assign b2    = (SUB2 != 0) ? bm_b[2] : bm_a[2];
        assign pm[l] = PW'(b0) + PW'(b1) + PW'(b2);
    end

    // Stage 2: register the leaf metrics and the threshold flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_pm    <= '0;
            s2_thr   <= '0;
            s2_valid <= 1'b0;
        end else begin
            s2_pm    <= pm;
            s2_thr   <= thr;
            s2_valid <= s1_valid;
        end
    end

    tsd_leaf_min #(
        .PW (PW)
    ) i_min (
        .pm      (s2_pm),
        .pair_le (pair_le)
    );

    tsd_bit_decoder i_dec (
        .pair_le (pair_le),
        .thr     (s2_thr),
        .win     (win),
        .data    (dec_data)
    );

    // Stage 3: register the decoded word; hold it when no word is valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s2_valid;
            if (s2_valid) out_data <= dec_data;
        end
    end
endmodule

// File: rtl/tsd_checker.sv
// Checker for tsd_top: latency, hold, and winner correctness and uniqueness.
// Bound to every tsd_top instance by the bind statement at the end.
module tsd_checker
    import tsd_pkg::*;
#(
    parameter int PW = 7
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic                          out_valid,
    input logic [DATA_BITS-1:0]          out_data,
    input logic [NUM_LEAVES-1:0][PW-1:0] pm,
    input logic [NUM_LEAVES-1:0]         win
);
    logic [2:0] vq;
    logic       min_ok;
    logic       tie_ok;

    // Shadow delay line for the valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) vq <= '0;
        else        vq <= {vq[1:0], in_valid};
    end

    // The winner has a metric no larger than any other leaf, and it is
    // strictly smaller than the metric of every lower-indexed leaf
    always_comb begin
        min_ok = 1'b1;
        tie_ok = 1'b1;
        for (int l = 0; l < NUM_LEAVES; l++) begin
            for (int j = 0; j < NUM_LEAVES; j++) begin
                if (win[l] && pm[l] > pm[j]) min_ok = 1'b0;
                if (win[l] && j < l && pm[j] <= pm[l]) tie_ok = 1'b0;
            end
        end
    end

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vq[2]);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));
    p_one_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(win) == 1);
    p_min_leaf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        min_ok);
    p_tie_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tie_ok);
endmodule

bind tsd_top tsd_checker #(.PW(PW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .pm        (s2_pm),
    .win       (win)
);

// File: tb/test_tsd_top.sv
`timescale 1ns/100ps
// Bench for tsd_top: directed corners plus seeded random stimulus,
// checked against a distance-based reference model.
module test_tsd_top;
    localparam int SW = 4;
    localparam int ST = 2;
    localparam int XMIN = -(1 << (SW - 1));
    localparam int XMAX = (1 << (SW - 1)) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [3*SW-1:0] in_samples = '0;
    logic          out_valid;
    logic [4:0]    out_data;

    int total = 0;
    int bad = 0;
    bit hv [3];
    int he [3];
    string ht [3];
    int last_exp = 0;

    tsd_top #(.SW(SW), .LEVEL_STEP(ST)) i_tsd_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_samples(in_samples), .out_valid(out_valid), .out_data(out_data)
    );

    always #2.5 clk = ~clk;

    function automatic int absv(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Nominal level for a subset (0 = A, 1 = B) and within-subset bit (R1)
    function automatic int level(input int sub, input int u);
        if (sub == 0) return u ? ST : -3 * ST;
        return u ? 3 * ST : -ST;
    endfunction

    function automatic int clip(input int v);
        return (v < XMIN) ? XMIN : ((v > XMAX) ? XMAX : v);
    endfunction

    // Reference: smallest summed distance, lower leaf on ties, upper on midpoint
    function automatic int ref_decode(input int x0, input int x1, input int x2);
        int xs [3];
        int best;
        int word;
        xs[0] = x0; xs[1] = x1; xs[2] = x2;
        best = 1 << 30;
        word = 0;
        for (int l = 0; l < 4; l++) begin
            int p0, p1, sum, w;
            int sub [3];
            int u [3];
            p0 = l / 2; p1 = l % 2;
            sub[0] = p0; sub[1] = p0 ^ p1; sub[2] = p1;
            sum = 0;
            for (int k = 0; k < 3; k++) begin
                int dl, dh;
                dl = absv(xs[k] - level(sub[k], 0));
                dh = absv(xs[k] - level(sub[k], 1));
                u[k] = (dh <= dl) ? 1 : 0;
                sum += u[k] ? dh : dl;
            end
            w = u[0] | (p0 << 1) | (u[1] << 2) | (p1 << 3) | (u[2] << 4);
            if (sum < best) begin
                best = sum;
                word = w;
            end
        end
        return word;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: check the output of three cycles ago, then drive a new set
    task automatic step(input bit v, input int x0, input int x1, input int x2,
                        input int exp, input string req);
        @(negedge clk);
        chk(out_valid == hv[2], "R3 valid", int'(out_valid), int'(hv[2]));
        if (hv[2]) begin
            chk(int'(out_data) == he[2], ht[2], int'(out_data), he[2]);
            last_exp = he[2];
        end else begin
            chk(int'(out_data) == last_exp, "R4 hold", int'(out_data), last_exp);
        end
        hv[2] = hv[1]; he[2] = he[1]; ht[2] = ht[1];
        hv[1] = hv[0]; he[1] = he[0]; ht[1] = ht[0];
        hv[0] = v; he[0] = exp; ht[0] = req;
        in_valid   = v;
        in_samples = {4'(x2), 4'(x1), 4'(x0)};
    endtask

    task automatic send(input int x0, input int x1, input int x2, input string req);
        step(1'b1, x0, x1, x2, ref_decode(x0, x1, x2), req);
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < 3; i++) begin
            hv[i] = 1'b0; he[i] = 0; ht[i] = "";
        end
        in_samples = {4'(5), 4'(-3), 4'(7)};
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R8 reset valid", int'(out_valid), 0);
        chk(out_data == 5'd0, "R8 reset data", int'(out_data), 0);
        rst_n = 1'b1;
        in_samples = '0;

        // R2: every word, noise-free, encoded with the R1 mapping
        for (int d = 0; d < 32; d++) begin
            int p0, p1;
            p0 = (d >> 1) & 1; p1 = (d >> 3) & 1;
            step(1'b1, level(p0, d & 1), level(p0 ^ p1, (d >> 2) & 1),
                 level(p1, (d >> 4) & 1), d, "R2 clean word");
        end

        // R7: all-zero samples tie all leaves; R5: samples at the thresholds
        send(0, 0, 0, "R7 tie all leaves");
        send(-ST, -ST, -ST, "R5 midpoint A");
        send(ST, ST, ST, "R5 midpoint B");
        send(ST, -ST, ST, "R5 R7 mixed midpoints");
        // R9: rail codes
        send(XMIN, XMIN, XMIN, "R9 negative rail");
        send(XMAX, XMAX, XMAX, "R9 positive rail");
        send(XMIN, XMAX, XMIN, "R9 mixed rails");
        send(XMAX, XMIN, XMAX, "R9 mixed rails");

        // R4 and R3: a gap in the valid flag
        for (int g = 0; g < 3; g++) step(1'b0, 3, -3, 1, 0, "R4 gap");

        // R6: noisy encoded words with random gaps
        for (int n = 0; n < 300; n++) begin
            int d, p0, p1;
            d = int'($urandom_range(31, 0));
            p0 = (d >> 1) & 1; p1 = (d >> 3) & 1;
            if ($urandom_range(3, 0) == 0) begin
                step(1'b0, 0, 0, 0, 0, "R4 random gap");
            end else begin
                send(clip(level(p0, d & 1) + int'($urandom_range(4, 0)) - 2),
                     clip(level(p0 ^ p1, (d >> 2) & 1) + int'($urandom_range(4, 0)) - 2),
                     clip(level(p1, (d >> 4) & 1) + int'($urandom_range(4, 0)) - 2),
                     "R6 noisy word");
            end
        end

        // R6: arbitrary sample sets
        for (int n = 0; n < 300; n++) begin
            send(int'($urandom_range(XMAX - XMIN, 0)) + XMIN,
                 int'($urandom_range(XMAX - XMIN, 0)) + XMIN,
                 int'($urandom_range(XMAX - XMIN, 0)) + XMIN, "R6 random samples");
        end

        for (int f = 0; f < 4; f++) step(1'b0, 0, 0, 0, 0, "R4 flush");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule